// File: doc/BRIEF.md
# Addressed Color Packet Receiver

This block sits behind a byte-level serial receiver on a shared multi-drop bus. It collects received bytes into fixed ten-byte command packets. A packet carries a command byte, a logical channel number, and four 16-bit color intensities in the order red, green, blue, white. When the last byte of a packet arrives, the block checks the command code and whether the channel number falls inside the window this board owns. If both checks pass, it commits all four intensities to a 32-entry raw channel register file in a single write cycle.

Several boards can share one bus. Each board is built with its own lowest channel number (`BASE_CHAN`) and owns `NUM_GROUPS` consecutive logical channels. Each logical channel covers four adjacent raw channels. The colors are permuted so that white lands on the lowest raw channel of the group, followed by red, green and blue.

Packet framing has no start marker. It is recovered with an inter-byte idle timeout: if a packet stalls part-way through, the next byte is treated as the first byte of a new packet. A byte flagged with a receive overrun is thrown away.

The control is one state machine with four states:
- `RX_CMD` waits for the command byte.
- `RX_CHAN` takes the channel byte.
- `RX_DATA` takes the eight color bytes.
- `RX_EVAL` lasts one cycle and decides whether to commit.

Its transitions are:
- *accept-cmd*: `RX_CMD` to `RX_CHAN`.
- *accept-chan*: `RX_CHAN` to `RX_DATA`.
- *last-data*: `RX_DATA` to `RX_EVAL`, on the eighth color byte.
- *idle-abort*: `RX_CHAN` or `RX_DATA` back to `RX_CMD`, when the timeout expires.
- *eval-done*: `RX_EVAL` to `RX_CMD`.
- *eval-chain*: `RX_EVAL` to `RX_CHAN`, when a new byte arrives during the evaluation cycle.

Top module: `rgbw_pkt_rx`

## Requirements
- R1: After reset, `wr_en` is low and the next accepted byte is taken as the command byte of a packet.
- R2: A packet is 10 accepted bytes in this order: command, channel, then four 16-bit values for R, G, B and W, each most significant byte first. When the packet passes its checks, `wr_en` is high for exactly one clock. That clock is the cycle right after the edge that captures the tenth byte.
- R3: Only command code 0x23 (`CMD_CODE`) produces a write. A packet with any other code still consumes all 10 bytes and then produces no write, and the byte after it starts a new packet.
- R4: A packet produces a write only if its channel byte `ch` satisfies `BASE_CHAN <= ch <= BASE_CHAN + NUM_GROUPS - 1`. `BASE_CHAN` defaults to 8 and `NUM_GROUPS` to 8.
- R5: During a write, `wr_base` equals `(ch - BASE_CHAN) * 4`, the raw index of the group's first channel.
- R6: During a write, `wr_data` holds one 16-bit lane per raw channel. Bits [15:0] go to raw channel `wr_base+0` and carry W. Bits [31:16] go to `wr_base+1` and carry R. Bits [47:32] go to `wr_base+2` and carry G. Bits [63:48] go to `wr_base+3` and carry B.
- R7: Within a packet, if the next accepted byte's strobe comes more than `TIMEOUT_CYCLES` clock edges after the previous accepted byte, framing restarts and that byte becomes a command byte. A byte arriving exactly `TIMEOUT_CYCLES` edges later continues the packet. While waiting for a command byte, idle time has no effect.
- R8: A byte strobed with `rx_overrun` high is dropped. It does not advance the byte position, does not change the stored bytes, and does not restart the idle timeout.
- R9: A byte accepted in the commit cycle is taken as the command byte of the next packet, so packets may arrive back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is valid |
| rx_overrun | input | 1 | The strobed byte was received with an overrun error |
| wr_en | output | 1 | Commit of four raw channel values |
| wr_base | output | $clog2(NUM_GROUPS)+2 | Raw index of the first channel of the group being written |
| wr_data | output | 64 | Four 16-bit lanes, lane k for raw channel `wr_base+k` |

## Verification
The bench builds the block with `TIMEOUT_CYCLES = 20`, so that the timeout edge (a gap of exactly the limit, and one cycle past it) takes only a few dozen cycles to reach. It uses `BASE_CHAN = 3` with the default eight groups. This moves the accepted window to channels 3 through 10, so both window edges and the channels just outside them are exercised at non-default values. A behavioural model tracks byte position and idle time and is compared with the outputs every cycle. Scenario checks cover overrun bytes mid-packet, an overrun that must not restart the timeout, and back-to-back packets.

// File: rtl/rgbw_rx_pkg.sv
package rgbw_rx_pkg;

    typedef enum logic [1:0] {
        RX_CMD  = 2'd0,
        RX_CHAN = 2'd1,
        RX_DATA = 2'd2,
        RX_EVAL = 2'd3
    } rx_state_e;

    localparam int COLOR_W    = 16;
    localparam int COLORS     = 4;
    localparam int DATA_BYTES = COLORS * COLOR_W / 8;
    localparam int PAYLOAD_W  = COLORS * COLOR_W;

    // Arrival order of colors: 0 = R, 1 = G, 2 = B, 3 = W.
    // Raw lane inside the group: W at lane 0, R/G/B at lanes 1..3.
    function automatic int lane_of_color(input int color_idx);
        return (color_idx + 1) % COLORS;
    endfunction

endpackage

// File: rtl/rgbw_idle_timer.sv
module rgbw_idle_timer #(
    parameter int TIMEOUT_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic kick,
    output logic expire
);

    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (kick || !armed) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LAST) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign expire = armed && !kick && (idle_cnt == LAST);

    // R7: the idle counter never runs past the timeout limit
    assert_idle_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LAST);

endmodule

// File: rtl/rgbw_frame_fsm.sv
module rgbw_frame_fsm
    import rgbw_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           byte_in,
    input  logic                 byte_ok,
    input  logic                 expire,
    output rx_state_e            state,
    output logic [7:0]           cmd_q,
    output logic [7:0]           chan_q,
    output logic [PAYLOAD_W-1:0] payload_q
);

    localparam int DCNT_W = $clog2(DATA_BYTES);
    localparam logic [DCNT_W-1:0] DCNT_LAST = DCNT_W'(DATA_BYTES - 1);

    rx_state_e         state_nxt;
    logic [DCNT_W-1:0] dcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_CMD;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_CMD: begin
                if (byte_ok) state_nxt = RX_CHAN;
            end
            RX_CHAN: begin
                if (byte_ok)     state_nxt = RX_DATA;
                else if (expire) state_nxt = RX_CMD;
            end
            RX_DATA: begin
                if (byte_ok && dcnt == DCNT_LAST) state_nxt = RX_EVAL;
                else if (!byte_ok && expire)      state_nxt = RX_CMD;
            end
            RX_EVAL: begin
                state_nxt = byte_ok ? RX_CHAN : RX_CMD;
            end
            default: state_nxt = RX_CMD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            chan_q    <= '0;
            payload_q <= '0;
            dcnt      <= '0;
        end else if (byte_ok) begin
            unique case (state)
                RX_CMD, RX_EVAL: cmd_q <= byte_in;
                RX_CHAN: begin
                    chan_q <= byte_in;
                    dcnt   <= '0;
                end
                RX_DATA: begin
                    payload_q <= {payload_q[PAYLOAD_W-9:0], byte_in};
                    dcnt      <= dcnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R2: the evaluation state lasts a single cycle
    assert_eval_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == RX_EVAL |=> state != RX_EVAL);

    // R7: idle time while waiting for a command byte changes nothing
    assert_cmd_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_CMD && !byte_ok) |=> state == RX_CMD);

    // R8: stored color bytes hold unless a byte is accepted
    assert_payload_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_ok |=> $stable(payload_q));

endmodule

// File: rtl/rgbw_commit_map.sv
module rgbw_commit_map
    import rgbw_rx_pkg::*;
#(
    parameter int         BASE_CHAN  = 8,
    parameter int         NUM_GROUPS = 8,
    parameter logic [7:0] CMD_CODE   = 8'h23
) (
    input  logic                            evaluate,
    input  logic [7:0]                      cmd_q,
    input  logic [7:0]                      chan_q,
    input  logic [PAYLOAD_W-1:0]            payload_q,
    output logic                            wr_en,
    output logic [$clog2(NUM_GROUPS)+1:0]   wr_base,
    output logic [PAYLOAD_W-1:0]            wr_data
);

    localparam int GRP_W = $clog2(NUM_GROUPS);
    localparam logic [9:0] LO = 10'(BASE_CHAN);
    localparam logic [9:0] HI = 10'(BASE_CHAN + NUM_GROUPS);

    logic [9:0] chan_w;
    logic [9:0] offset;
    logic       in_window;

    assign chan_w    = {2'b00, chan_q};
    assign in_window = (chan_w >= LO) && (chan_w < HI);
    assign offset    = chan_w - LO;
    assign wr_base   = {offset[GRP_W-1:0], 2'b00};
    assign wr_en     = evaluate && (cmd_q == CMD_CODE) && in_window;

    for (genvar c = 0; c < COLORS; c++) begin : g_lane
        localparam int LANE = lane_of_color(c);
        assign wr_data[LANE*COLOR_W +: COLOR_W] =
            payload_q[(COLORS-1-c)*COLOR_W +: COLOR_W];
    end

endmodule

// File: rtl/rgbw_pkt_rx.sv
module rgbw_pkt_rx
    import rgbw_rx_pkg::*;
#(
    parameter int         BASE_CHAN      = 8,
    parameter int         NUM_GROUPS     = 8,
    parameter logic [7:0] CMD_CODE       = 8'h23,
    parameter int         TIMEOUT_CYCLES = 50000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [7:0]                    rx_byte,
    input  logic                          rx_valid,
    input  logic                          rx_overrun,
    output logic                          wr_en,
    output logic [$clog2(NUM_GROUPS)+1:0] wr_base,
    output logic [63:0]                   wr_data
);

    rx_state_e            state;
    logic                 byte_ok;
    logic                 armed;
    logic                 expire;
    logic [7:0]           cmd_q;
    logic [7:0]           chan_q;
    logic [PAYLOAD_W-1:0] payload_q;

    assign byte_ok = rx_valid && !rx_overrun;
    assign armed   = (state == RX_CHAN) || (state == RX_DATA);

    rgbw_idle_timer #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (armed),
        .kick   (byte_ok),
        .expire (expire)
    );

    rgbw_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_in   (rx_byte),
        .byte_ok   (byte_ok),
        .expire    (expire),
        .state     (state),
        .cmd_q     (cmd_q),
        .chan_q    (chan_q),
        .payload_q (payload_q)
    );

    rgbw_commit_map #(
        .BASE_CHAN  (BASE_CHAN),
        .NUM_GROUPS (NUM_GROUPS),
        .CMD_CODE   (CMD_CODE)
    ) u_map (
        .evaluate  (state == RX_EVAL),
        .cmd_q     (cmd_q),
        .chan_q    (chan_q),
        .payload_q (payload_q),
        .wr_en     (wr_en),
        .wr_base   (wr_base),
        .wr_data   (wr_data)
    );

    // R2: a commit always follows the edge that accepted a byte
    assert_commit_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rx_valid && !rx_overrun));

    // R2: a commit is a single-cycle pulse
    assert_commit_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R8: an overrun strobe alone never produces a commit on the next cycle
    assert_overrun_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_overrun) |=> !wr_en);

endmodule

// File: tb/sim_rgbw_pkt_rx.sv
module sim_rgbw_pkt_rx;

    localparam int T    = 20;
    localparam int BASE = 3;
    localparam int NG   = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  rx_byte = 0;
    logic        rx_valid = 0;
    logic        rx_overrun = 0;
    logic        wr_en;
    logic [4:0]  wr_base;
    logic [63:0] wr_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rgbw_pkt_rx #(
        .BASE_CHAN(BASE), .NUM_GROUPS(NG), .CMD_CODE(8'h23), .TIMEOUT_CYCLES(T)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_overrun(rx_overrun), .wr_en(wr_en), .wr_base(wr_base), .wr_data(wr_data)
    );

    // Behavioural reference: byte position (10 = commit cycle) and idle time
    int         m_pos = 0;
    int         m_idle = 0;
    logic [7:0] m_buf [10];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0;
            m_idle = 0;
        end else begin
            int p;
            p = (m_pos == 10) ? 0 : m_pos;
            if (rx_valid && !rx_overrun) begin
                m_buf[p] = rx_byte;
                m_idle = 0;
                m_pos = (p == 9) ? 10 : p + 1;
            end else if (p != 0) begin
                if (m_idle == T - 1) begin
                    m_pos = 0;
                    m_idle = 0;
                end else begin
                    m_idle = m_idle + 1;
                    m_pos = p;
                end
            end else begin
                m_pos = 0;
                m_idle = 0;
            end
        end
    end

    int          wr_count = 0;
    logic [4:0]  last_base;
    logic [63:0] last_data;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_en;
            int ch;
            logic [63:0] exp_data;
            ch = m_buf[1];
            exp_en = (m_pos == 10) && (m_buf[0] == 8'h23) && ch >= BASE && ch < BASE + NG;
            exp_data = {m_buf[6], m_buf[7], m_buf[4], m_buf[5],
                        m_buf[2], m_buf[3], m_buf[8], m_buf[9]};
            checks++;
            if (wr_en !== exp_en) begin
                errors++;
                $display("FAIL R2 wr_en act=%0b exp=%0b at cycle %0d", wr_en, exp_en, cyc);
            end
            if (exp_en) begin
                checks++;
                if (wr_base !== 5'((ch - BASE) * 4)) begin
                    errors++;
                    $display("FAIL R5 wr_base act=%0d exp=%0d", wr_base, (ch - BASE) * 4);
                end
                checks++;
                if (wr_data !== exp_data) begin
                    errors++;
                    $display("FAIL R6 wr_data act=%h exp=%h", wr_data, exp_data);
                end
            end
            if (wr_en) begin
                wr_count++;
                last_base = wr_base;
                last_data = wr_data;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog act=%0d cycles exp=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ovr, input int gap);
        rx_byte = b;
        rx_overrun = ovr;
        rx_valid = 1;
        @(negedge clk);
        rx_valid = 0;
        rx_overrun = 0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_pkt(input logic [7:0] cmd, input logic [7:0] ch,
                            input logic [15:0] r, input logic [15:0] g,
                            input logic [15:0] b, input logic [15:0] w,
                            input int gap, input bit junk);
        logic [7:0] bytes [10];
        bytes = '{cmd, ch, r[15:8], r[7:0], g[15:8], g[7:0],
                  b[15:8], b[7:0], w[15:8], w[7:0]};
        for (int i = 0; i < 10; i++) begin
            send_byte(bytes[i], 0, gap);
            if (junk && i < 9) send_byte(8'hFF, 1, gap);
        end
    endtask

    int wc;

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        check("R1 wr_en in reset", {63'd0, wr_en}, 64'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check("R1 wr_en after reset", {63'd0, wr_en}, 64'd0);

        // R2 R5 R6: lowest channel in window
        wc = wr_count;
        send_pkt(8'h23, 8'd3, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1, 0);
        repeat (2) @(negedge clk);
        check("R2 one write", 64'(wr_count - wc), 64'd1);
        check("R5 base of ch3", 64'(last_base), 64'd0);
        check("R6 lanes B,G,R,W", last_data, 64'h9ABC_5678_1234_DEF0);

        // R4 R5: highest channel in window
        wc = wr_count;
        send_pkt(8'h23, 8'd10, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'h0001, 0, 0);
        repeat (2) @(negedge clk);
        check("R4 ch10 accepted", 64'(wr_count - wc), 64'd1);
        check("R5 base of ch10", 64'(last_base), 64'd28);

        // R4: just outside the window on both sides
        wc = wr_count;
        send_pkt(8'h23, 8'd11, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 0, 0);
        send_pkt(8'h23, 8'd2,  16'h1111, 16'h2222, 16'h3333, 16'h4444, 0, 0);
        repeat (2) @(negedge clk);
        check("R4 ch11 and ch2 rejected", 64'(wr_count - wc), 64'd0);

        // R3: wrong command consumes 10 bytes, next packet is framed correctly
        wc = wr_count;
        send_pkt(8'h24, 8'd5, 16'h0F0F, 16'hF0F0, 16'h00FF, 16'hFF00, 1, 0);
        repeat (2) @(negedge clk);
        check("R3 bad command no write", 64'(wr_count - wc), 64'd0);
        send_pkt(8'h23, 8'd5, 16'h0102, 16'h0304, 16'h0506, 16'h0708, 1, 0);
        repeat (2) @(negedge clk);
        check("R3 following packet written", 64'(wr_count - wc), 64'd1);
        check("R3 following packet data", last_data, 64'h0506_0304_0102_0708);

        // R8: overrun bytes interleaved are dropped
        wc = wr_count;
        send_pkt(8'h23, 8'd6, 16'hCAFE, 16'hBEEF, 16'hF00D, 16'h7777, 1, 1);
        repeat (2) @(negedge clk);
        check("R8 write with overruns", 64'(wr_count - wc), 64'd1);
        check("R8 data unaffected", last_data, 64'hF00D_BEEF_CAFE_7777);

        // R7: gap of exactly T edges continues the packet
        wc = wr_count;
        send_pkt(8'h23, 8'd7, 16'h1357, 16'h2468, 16'h9BDF, 16'hACE0, T - 1, 0);
        check("R7 gap at limit continues", 64'(wr_count - wc), 64'd1);
        check("R7 gap at limit data", last_data, 64'h9BDF_2468_1357_ACE0);

        // R7: gap one past the limit restarts framing
        wc = wr_count;
        send_byte(8'h23, 0, 0);
        send_byte(8'd4, 0, 0);
        send_byte(8'h55, 0, 0);
        send_byte(8'h66, 0, T);
        send_pkt(8'h23, 8'd8, 16'h0A0B, 16'h0C0D, 16'h0E0F, 16'h1020, 0, 0);
        repeat (2) @(negedge clk);
        check("R7 restart one write", 64'(wr_count - wc), 64'd1);
        check("R7 restart base", 64'(last_base), 64'd20);
        check("R7 restart data", last_data, 64'h0E0F_0C0D_0A0B_1020);

        // R8: an overrun strobe does not restart the idle timeout
        wc = wr_count;
        send_byte(8'h23, 0, 0);
        send_byte(8'd9, 0, 0);
        send_byte(8'h11, 0, T - 5);
        send_byte(8'hEE, 1, 10);
        send_pkt(8'h23, 8'd9, 16'h4321, 16'h8765, 16'hCBA9, 16'h0FED, 0, 0);
        repeat (2) @(negedge clk);
        check("R8 timeout kept one write", 64'(wr_count - wc), 64'd1);
        check("R8 timeout kept data", last_data, 64'hCBA9_8765_4321_0FED);

        // R9: back-to-back packets with no gap
        wc = wr_count;
        send_pkt(8'h23, 8'd4, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 0, 0);
        send_pkt(8'h23, 8'd5, 16'h5555, 16'h6666, 16'h7777, 16'h8888, 0, 0);
        repeat (2) @(negedge clk);
        check("R9 two writes", 64'(wr_count - wc), 64'd2);
        check("R9 second base", 64'(last_base), 64'd8);
        check("R9 second data", last_data, 64'h7777_6666_5555_8888);

        // R7: long idle at byte 0 has no effect
        wc = wr_count;
        repeat (3 * T) @(negedge clk);
        send_pkt(8'h23, 8'd3, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 0, 0);
        repeat (2) @(negedge clk);
        check("R7 idle at byte 0", 64'(wr_count - wc), 64'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule